// File: doc/BRIEF.md
# Signed/Unsigned Parallel Array Multiplier

This block multiplies two operands of `WIDTH` bits and returns a product of twice that width. All partial products are formed in parallel, one per bit of operand A, each being operand B gated by that bit. The rows are then summed in a single combinational pass, so the product settles in the same cycle as its inputs, with no clock in that path.

A single mode input picks how the operands are read: as unsigned binary, or as two's-complement signed values. In signed mode the array is not sign-extended and no separate negation step is used. Instead, a fixed set of partial-product bits is inverted and two constant ones are added into the sum. In every row except the one weighted by A's top bit, the row's top bit is flipped. In that last row every bit but the top one is flipped. One constant sits at column `WIDTH` and the other at column `2*WIDTH-1`.

An optional output register, selected by a parameter, captures the product whenever the input valid is high. It raises an output valid one cycle later. The unregistered product is always available on its own port.

Top module: `mul_array_top`

## Requirements
- R1: Partial-product row i equals operand B when bit i of operand A is 1, and is all zeros when that bit is 0, before any signed-mode inversion.
- R2: With `signed_mode` = 0, `prod_now` equals the unsigned product A×B over the full 2×WIDTH bits.
- R3: With `signed_mode` = 1, `prod_now` equals the exact two's-complement product of A and B, read as signed WIDTH-bit values, over 2×WIDTH bits.
- R4: Signed extremes are exact: (−128)×(−128) gives 0x4000 (+16384), and (−128)×127 gives 0xC080 (−16256), for WIDTH = 8.
- R5: `prod_now` follows changes of A, B or `signed_mode` with no clock edge.
- R6: With the output register fitted, a clock edge with `in_vld` = 1 loads `prod_q` with the current `prod_now`, and `out_vld` is 1 after that edge.
- R7: With the output register fitted, a clock edge with `in_vld` = 0 leaves `prod_q` unchanged, and `out_vld` is 0 after that edge.
- R8: While `rst_n` is 0, `prod_q` and `out_vld` are 0.
- R9: A zero operand gives a zero product in both modes, even though the signed array inverts bits and adds constants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| in_vld | input | 1 | Load enable for the output register |
| opnd_a | input | WIDTH | Operand A; each bit selects one partial-product row |
| opnd_b | input | WIDTH | Operand B; the value gated into each row |
| prod_now | output | 2*WIDTH | Combinational product |
| prod_q | output | 2*WIDTH | Registered product (equals `prod_now` when no register is fitted) |
| out_vld | output | 1 | Valid for `prod_q` |

## Verification
The bench builds the block at WIDTH = 8 with the output register fitted. At that width every operand pair in both modes can be checked on the combinational output, so the bench covers the full 131,072-point space. That includes both signed extremes and every inverted-bit pattern of the last row. Fitting the register brings load, hold and reset behaviour within reach, and these are exercised with random valid patterns.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  // Positions of the two correction ones used by the signed array,
  // relative to the operand width.
  function automatic int low_const_col(input int w);
    return w;
  endfunction

  function automatic int high_const_col(input int w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
  parameter int WIDTH = 8,
  localparam int PW   = 2 * WIDTH
) (
  input  logic                       sgn,
  input  logic [WIDTH-1:0]           a,
  input  logic [WIDTH-1:0]           b,
  output logic [WIDTH-1:0][PW-1:0]   rows
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [WIDTH-1:0] raw;
    logic [WIDTH-1:0] flip;
    logic [WIDTH-1:0] bits;

    assign raw = b & {WIDTH{a[i]}};

    if (i == WIDTH - 1) begin : g_neg_row
      // top row carries a negative weight: lower bits inverted
      assign flip = {1'b0, {(WIDTH-1){1'b1}}};
    end else begin : g_pos_row
      // ordinary row: only its top bit inverted
      assign flip = {1'b1, {(WIDTH-1){1'b0}}};
    end

    assign bits    = raw ^ (flip & {WIDTH{sgn}});
    assign rows[i] = PW'({{WIDTH{1'b0}}, bits} << i);

    // R1
    pp_gate_chk: assert final ((a[i] == 1'b1) ? (raw == b) : (raw == '0));
  end

endmodule

// File: rtl/mul_row_adder.sv
module mul_row_adder #(
  parameter int WIDTH = 8,
  localparam int PW   = 2 * WIDTH
) (
  input  logic                     sgn,
  input  logic [WIDTH-1:0][PW-1:0] rows,
  output logic [PW-1:0]            sum
);

  import mul_pkg::*;

  localparam logic [PW-1:0] CORR =
    (PW'(1) << low_const_col(WIDTH)) | (PW'(1) << high_const_col(WIDTH));

  logic [WIDTH:0][PW-1:0] acc;

  assign acc[0] = sgn ? CORR : '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign acc[i+1] = acc[i] + rows[i];
  end

  assign sum = acc[WIDTH];

endmodule

// File: rtl/mul_out_stage.sv
module mul_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          vld
);

  logic [DW-1:0] q_nxt;
  logic          vld_nxt;

  always_comb begin
    q_nxt   = q;
    vld_nxt = en;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= q_nxt;
      vld <= vld_nxt;
    end
  end

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (vld && q == $past(d)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!vld && $stable(q)));

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (q == '0 && vld == 1'b0);
    end
  end

endmodule

// File: rtl/mul_array_top.sv
module mul_array_top #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int PW     = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             signed_mode,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [PW-1:0]    prod_now,
  output logic [PW-1:0]    prod_q,
  output logic             out_vld
);

  import mul_pkg::*;

  mul_mode_e               mode;
  logic                    sgn;
  logic [WIDTH-1:0][PW-1:0] rows;

  assign mode = mul_mode_e'(signed_mode);
  assign sgn  = (mode == MODE_SIGNED);

  mul_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .sgn  (sgn),
    .a    (opnd_a),
    .b    (opnd_b),
    .rows (rows)
  );

  mul_row_adder #(.WIDTH(WIDTH)) u_sum (
    .sgn  (sgn),
    .rows (rows),
    .sum  (prod_now)
  );

  if (REG_OUT) begin : g_reg
    mul_out_stage #(.DW(PW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_vld),
      .d     (prod_now),
      .q     (prod_q),
      .vld   (out_vld)
    );
  end else begin : g_bypass
    assign prod_q  = prod_now;
    assign out_vld = in_vld;
  end

  // Behavioural references for the array checks.
  logic [PW-1:0] ref_u;
  logic [PW-1:0] ref_s;
  assign ref_u = PW'(opnd_a) * PW'(opnd_b);
  assign ref_s = PW'($signed({{WIDTH{opnd_a[WIDTH-1]}}, opnd_a}) *
                     $signed({{WIDTH{opnd_b[WIDTH-1]}}, opnd_b}));

  // R2
  uns_prod_chk: assert final (sgn || prod_now == ref_u);

  // R3
  sgn_prod_chk: assert final (!sgn || prod_now == ref_s);

  // R9
  zero_prod_chk: assert final ((opnd_a != '0 && opnd_b != '0) || prod_now == '0);

endmodule

// File: tb/mul_array_top_test.sv
module mul_array_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int PW = 16;

  logic          clk;
  logic          rst_n;
  logic          signed_mode;
  logic          in_vld;
  logic [W-1:0]  opnd_a;
  logic [W-1:0]  opnd_b;
  logic [PW-1:0] prod_now;
  logic [PW-1:0] prod_q;
  logic          out_vld;

  int n_checks;
  int n_fails;
  bit done;

  mul_array_top #(.WIDTH(W), .REG_OUT(1'b1)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .signed_mode (signed_mode),
    .in_vld      (in_vld),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .prod_now    (prod_now),
    .prod_q      (prod_q),
    .out_vld     (out_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PW-1:0] expect_prod(input logic s,
                                                input logic [W-1:0] a,
                                                input logic [W-1:0] b);
    int ia, ib;
    ia = int'(a);
    ib = int'(b);
    if (s) begin
      if (a[W-1]) ia = ia - 256;
      if (b[W-1]) ib = ib - 256;
    end
    return PW'(ia * ib);
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h s=%0d)",
               req, act, exp, opnd_a, opnd_b, signed_mode);
    end
  endtask

  task automatic comb_pair(input logic s, input logic [W-1:0] a,
                           input logic [W-1:0] b, input string req);
    signed_mode = s;
    opnd_a      = a;
    opnd_b      = b;
    #1;
    check(req, prod_now, expect_prod(s, a, b));
  endtask

  initial begin
    logic [PW-1:0] held;
    n_checks    = 0;
    n_fails     = 0;
    done        = 1'b0;
    rst_n       = 1'b1;
    in_vld      = 1'b0;
    signed_mode = 1'b0;
    opnd_a      = '0;
    opnd_b      = '0;
    void'($urandom(32'd1234));
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 prod_q", prod_q, '0);
    check("R8 out_vld", PW'(out_vld), '0);
    // R8: reset holds even with a load requested
    in_vld = 1'b1; opnd_a = 8'hff; opnd_b = 8'hff;
    @(negedge clk);
    check("R8 prod_q under load", prod_q, '0);
    in_vld = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);

    // R4: signed extremes
    comb_pair(1'b1, 8'h80, 8'h80, "R4 -128*-128");
    check("R4 -128*-128 const", prod_now, 16'h4000);
    comb_pair(1'b1, 8'h80, 8'h7f, "R4 -128*127");
    check("R4 -128*127 const", prod_now, 16'hc080);
    comb_pair(1'b1, 8'hff, 8'hff, "R3 -1*-1");
    comb_pair(1'b0, 8'hff, 8'hff, "R2 255*255");
    comb_pair(1'b0, 8'h0b, 8'h0e, "R2 11*14");
    // R9: zero operands in both modes
    comb_pair(1'b1, 8'h00, 8'h80, "R9 signed zero a");
    comb_pair(1'b1, 8'h9c, 8'h00, "R9 signed zero b");
    comb_pair(1'b0, 8'h00, 8'hff, "R9 unsigned zero");
    // R1: a single-bit A selects exactly one row of B
    for (int i = 0; i < W; i++) begin
      comb_pair(1'b0, 8'(1 << i), 8'ha5, "R1 single row");
    end
    // R5: mode flip alone changes the output with no clock edge
    comb_pair(1'b0, 8'hf0, 8'h03, "R5 unsigned view");
    signed_mode = 1'b1; #1;
    check("R5 mode change", prod_now, expect_prod(1'b1, 8'hf0, 8'h03));

    // R2 / R3: every operand pair, both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          comb_pair(s[0], a[7:0], b[7:0], s ? "R3 exhaustive" : "R2 exhaustive");
        end
      end
    end

    // R6 / R7: random load and hold through the output register
    @(negedge clk);
    held = prod_q;
    for (int k = 0; k < 2000; k++) begin
      logic v;
      logic [PW-1:0] want;
      v           = ($urandom % 3) != 0;
      in_vld      = v;
      signed_mode = $urandom % 2;
      opnd_a      = $urandom;
      opnd_b      = $urandom;
      want        = v ? expect_prod(signed_mode, opnd_a, opnd_b) : held;
      @(negedge clk);
      if (v) begin
        check("R6 load", prod_q, want);
        check("R6 out_vld", PW'(out_vld), 16'd1);
      end else begin
        check("R7 hold", prod_q, want);
        check("R7 out_vld", PW'(out_vld), 16'd0);
      end
      held = want;
    end
    in_vld = 1'b0;

    // R8: asynchronous reset clears a loaded register
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R8 async prod_q", prod_q, '0);
    check("R8 async out_vld", PW'(out_vld), '0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule